// File: doc/BRIEF.md
# UART Interrupt Status Unit

This block collects the event pulses of a serial port and turns them into a status word and one interrupt line. Transmit demand, framing error, break and receive overrun are latched into sticky status bits. Those bits stay set until software writes a one to them. The receive trigger and receive timeout conditions are not latched: they appear in the status word as live levels, one clock after the input. A further status bit shows that a transmit demand is pending while transmit interrupts are enabled.

A small control register holds three enables, one each for the transmit, receive and error groups. The interrupt line is the registered OR of every group whose enable is set and whose status bits are non-zero. Software reads the status word through a read strobe that captures it into a read data register. A read never changes any state. All outputs come from flip-flops. The reset is synchronous and active high.

Top module: `isu_irq_status`

## Requirements
- R1: While reset is high, and after the first clock edge with reset high, status_o, rd_data and irq_o are all zero and all three enables are cleared.
- R2: A one-cycle pulse on ev_tx_req, ev_frame, ev_break or ev_overrun sets status bit 0, 3, 4 or 5 respectively at that clock edge, and the bit stays set afterwards until it is cleared.
- R3: A stat_wr cycle with wr_data bit 0, 3, 4 or 5 at one clears that latched bit at that edge. A stat_wr cycle with a zero in those positions leaves the bit unchanged.
- R4: If an event pulse and a clearing write reach the same latched bit in the same cycle, the bit is set after that edge.
- R5: Status bit 1 equals rx_trig_lvl and status bit 2 equals rx_tmo_lvl, each as sampled at the previous clock edge. Writes do not affect these two bits.
- R6: Status bit 6 is one exactly when the next value of bit 0 is one and the next value of the transmit enable is one. The transmit enable is control bit 5, written with ctl_wr and wr_data.
- R7: irq_o is registered. At each edge it takes the OR of three terms, using the status and enables from before that edge: transmit enable (control bit 5) with bit 0; receive enable (control bit 6) with bits 1 or 2; error enable (control bit 7) with bits 3, 4 or 5.
- R8: A stat_rd cycle loads rd_data with the status word present before that edge. Without stat_rd, rd_data holds its value, and a read changes no status bit.
- R9: Status bits 7 and above always read zero, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_tx_req | input | 1 | Transmit demand pulse |
| rx_trig_lvl | input | 1 | Live receive trigger condition |
| rx_tmo_lvl | input | 1 | Live receive timeout condition |
| ev_frame | input | 1 | Framing error pulse |
| ev_break | input | 1 | Break received pulse |
| ev_overrun | input | 1 | Receive overrun pulse |
| stat_wr | input | 1 | Write strobe for the status word (write one to clear) |
| ctl_wr | input | 1 | Write strobe for the enable register |
| wr_data | input | WORD_W | Write data shared by both strobes |
| stat_rd | input | 1 | Read strobe for the status word |
| status_o | output | WORD_W | Current status word |
| rd_data | output | WORD_W | Status word captured by the last read |
| irq_o | output | 1 | Interrupt request |

## Verification
A latched bit that is lost, set wrongly or fails to clear shows on status_o at the first edge after the event or write. It then reaches irq_o one edge later, provided its group is enabled. A wrong enable state is seen directly on status bit 6, which follows the transmit enable at the same edge as the write. The receive and error enables are only visible through irq_o, one cycle after the status changes. A fault in the read path shows on rd_data at the edge of the strobe, or as a change of rd_data when no read is made.

// File: rtl/isu_pkg.sv
package isu_pkg;
  // Status bit positions. Software decodes these, so they are fixed.
  localparam int unsigned B_TX_REQ  = 0;
  localparam int unsigned B_RX_TRIG = 1;
  localparam int unsigned B_RX_TMO  = 2;
  localparam int unsigned B_FRAME   = 3;
  localparam int unsigned B_BREAK   = 4;
  localparam int unsigned B_OVERRUN = 5;
  localparam int unsigned B_TX_SET  = 6;
  localparam int unsigned N_EVENTS  = 6;
  localparam int unsigned N_STATUS  = 7;

  // Control positions of the three group enables.
  localparam int unsigned C_TX_EN   = 5;
  localparam int unsigned C_RX_EN   = 6;
  localparam int unsigned C_ERR_EN  = 7;
  localparam int unsigned MIN_WORD  = 8;

  // A one marks a sticky, write-one-to-clear bit; a zero marks a live level.
  localparam logic [N_EVENTS-1:0] STICKY_MASK = 6'b111001;

  typedef struct packed {
    logic err;
    logic rx;
    logic tx;
  } isu_en_t;
endpackage

// File: rtl/isu_status_bit.sv
module isu_status_bit #(
  parameter bit STICKY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  generate
    if (STICKY) begin : g_sticky
      // A new event takes priority over a clear in the same cycle.
      assign nxt_o = ev_i | (q_o & ~clr_i);
    end else begin : g_live
      assign nxt_o = ev_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= nxt_o;
  end
endmodule

// File: rtl/isu_enable_reg.sv
module isu_enable_reg
  import isu_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] wr_data,
  output isu_en_t           en_nxt,
  output isu_en_t           en_q
);
  always_comb begin
    en_nxt = en_q;
    if (ctl_wr) begin
      en_nxt.tx  = wr_data[C_TX_EN];
      en_nxt.rx  = wr_data[C_RX_EN];
      en_nxt.err = wr_data[C_ERR_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end
endmodule

// File: rtl/isu_irq_gate.sv
module isu_irq_gate
  import isu_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [N_EVENTS-1:0] st_q,
  input  isu_en_t             en_q,
  output logic                irq_o
);
  logic grp_tx, grp_rx, grp_err;

  always_comb begin
    grp_tx  = en_q.tx  & st_q[B_TX_REQ];
    grp_rx  = en_q.rx  & (st_q[B_RX_TRIG] | st_q[B_RX_TMO]);
    grp_err = en_q.err & (st_q[B_FRAME] | st_q[B_BREAK] | st_q[B_OVERRUN]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= grp_tx | grp_rx | grp_err;
  end
endmodule

// File: rtl/isu_irq_status.sv
module isu_irq_status
  import isu_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_tx_req,
  input  logic              rx_trig_lvl,
  input  logic              rx_tmo_lvl,
  input  logic              ev_frame,
  input  logic              ev_break,
  input  logic              ev_overrun,
  input  logic              stat_wr,
  input  logic              ctl_wr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_o
);
  // WORD_W must be at least MIN_WORD so that the enable positions exist.
  localparam int unsigned PAD_W = WORD_W - N_STATUS;

  logic [N_EVENTS-1:0] ev_vec;
  logic [N_EVENTS-1:0] clr_vec;
  logic [N_EVENTS-1:0] st_nxt;
  logic [N_EVENTS-1:0] st_q;
  logic                tx_set_q;
  isu_en_t             en_nxt;
  isu_en_t             en_q;

  assign ev_vec[B_TX_REQ]  = ev_tx_req;
  assign ev_vec[B_RX_TRIG] = rx_trig_lvl;
  assign ev_vec[B_RX_TMO]  = rx_tmo_lvl;
  assign ev_vec[B_FRAME]   = ev_frame;
  assign ev_vec[B_BREAK]   = ev_break;
  assign ev_vec[B_OVERRUN] = ev_overrun;

  assign clr_vec = stat_wr ? wr_data[N_EVENTS-1:0] : '0;

  for (genvar i = 0; i < N_EVENTS; i++) begin : g_bit
    isu_status_bit #(
      .STICKY(STICKY_MASK[i])
    ) u_bit (
      .clk   (clk),
      .rst   (rst),
      .ev_i  (ev_vec[i]),
      .clr_i (clr_vec[i]),
      .nxt_o (st_nxt[i]),
      .q_o   (st_q[i])
    );
  end

  isu_enable_reg #(
    .WORD_W(WORD_W)
  ) u_en (
    .clk     (clk),
    .rst     (rst),
    .ctl_wr  (ctl_wr),
    .wr_data (wr_data),
    .en_nxt  (en_nxt),
    .en_q    (en_q)
  );

  // Transmit-set flag is formed from next-state values so it lines up with bit 0.
  always_ff @(posedge clk) begin
    if (rst) tx_set_q <= 1'b0;
    else     tx_set_q <= st_nxt[B_TX_REQ] & en_nxt.tx;
  end

  isu_irq_gate u_gate (
    .clk   (clk),
    .rst   (rst),
    .st_q  (st_q),
    .en_q  (en_q),
    .irq_o (irq_o)
  );

  assign status_o = {{PAD_W{1'b0}}, tx_set_q, st_q};

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (stat_rd) rd_data <= status_o;
  end
endmodule

// File: rtl/isu_irq_status_chk.sv
module isu_irq_status_chk
  import isu_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ev_tx_req,
  input logic              rx_trig_lvl,
  input logic              rx_tmo_lvl,
  input logic              ev_frame,
  input logic              ev_break,
  input logic              ev_overrun,
  input logic              stat_wr,
  input logic [WORD_W-1:0] wr_data,
  input logic              stat_rd,
  input logic [WORD_W-1:0] status_o,
  input logic [WORD_W-1:0] rd_data,
  input logic              irq_o
);
  logic [N_EVENTS-1:0] evs;
  assign evs = {ev_overrun, ev_break, ev_frame, rx_tmo_lvl, rx_trig_lvl, ev_tx_req};

  for (genvar i = 0; i < N_EVENTS; i++) begin : g_sticky
    if (STICKY_MASK[i]) begin : g_on
      p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(evs[i]) |-> status_o[i]);
      p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(status_o[i]) && !$past(stat_wr && wr_data[i]) |-> status_o[i]);
      p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(stat_wr && wr_data[i] && !evs[i]) |-> !status_o[i]);
      p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && $past(stat_wr && wr_data[i] && evs[i]) |-> status_o[i]);
    end
  end

  p_live_levels_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_o[B_RX_TRIG] == $past(rx_trig_lvl)) &&
                    (status_o[B_RX_TMO]  == $past(rx_tmo_lvl)));

  p_txset_implies_req_r6: assert property (@(posedge clk) disable iff (rst)
    status_o[B_TX_SET] |-> status_o[B_TX_REQ]);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && ($past(status_o[N_EVENTS-1:0]) == '0) |-> !irq_o);

  p_read_capture_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(stat_rd) |-> rd_data == $past(status_o));

  p_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(stat_rd) |-> $stable(rd_data));
endmodule

bind isu_irq_status isu_irq_status_chk #(
  .WORD_W(WORD_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_tx_req   (ev_tx_req),
  .rx_trig_lvl (rx_trig_lvl),
  .rx_tmo_lvl  (rx_tmo_lvl),
  .ev_frame    (ev_frame),
  .ev_break    (ev_break),
  .ev_overrun  (ev_overrun),
  .stat_wr     (stat_wr),
  .wr_data     (wr_data),
  .stat_rd     (stat_rd),
  .status_o    (status_o),
  .rd_data     (rd_data),
  .irq_o       (irq_o)
);

// File: tb/test_isu_irq_status.sv
`timescale 1ns/1ps
module test_isu_irq_status;
  localparam int unsigned W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic ev_tx_req = 0, rx_trig_lvl = 0, rx_tmo_lvl = 0;
  logic ev_frame = 0, ev_break = 0, ev_overrun = 0;
  logic stat_wr = 0, ctl_wr = 0, stat_rd = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] status_o, rd_data;
  logic irq_o;

  isu_irq_status #(.WORD_W(W)) i_isu_irq_status (
    .clk(clk), .rst(rst), .ev_tx_req(ev_tx_req), .rx_trig_lvl(rx_trig_lvl),
    .rx_tmo_lvl(rx_tmo_lvl), .ev_frame(ev_frame), .ev_break(ev_break),
    .ev_overrun(ev_overrun), .stat_wr(stat_wr), .ctl_wr(ctl_wr),
    .wr_data(wr_data), .stat_rd(stat_rd), .status_o(status_o),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  typedef struct {
    logic [W-1:0] st;
    logic [W-1:0] rd;
    logic         irq;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails  = 0;

  // Reference state built from the requirements.
  logic [W-1:0] m_st = '0;
  logic [W-1:0] m_rd = '0;
  logic [2:0]   m_en = '0; // [0] tx, [1] rx, [2] err

  task automatic check_now(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, predict the result, queue it.
  task automatic step(input logic [5:0] ev, input logic s_wr, input logic c_wr,
                      input logic [W-1:0] d, input logic rd, input string tag);
    logic [W-1:0] ns;
    logic [W-1:0] clr;
    logic [2:0]   en_n;
    logic         irq_n;
    exp_t         e;
    {ev_overrun, ev_break, ev_frame, rx_tmo_lvl, rx_trig_lvl, ev_tx_req} = ev;
    stat_wr = s_wr; ctl_wr = c_wr; wr_data = d; stat_rd = rd;
    @(posedge clk);
    clr  = s_wr ? d : '0;
    en_n = c_wr ? d[7:5] : m_en;
    ns = '0;
    ns[0] = ev[0] | (m_st[0] & ~clr[0]);
    ns[1] = ev[1];
    ns[2] = ev[2];
    for (int j = 3; j < 6; j++) ns[j] = ev[j] | (m_st[j] & ~clr[j]);
    ns[6] = ns[0] & en_n[0];
    irq_n = (m_en[0] & m_st[0]) | (m_en[1] & (m_st[1] | m_st[2])) |
            (m_en[2] & (m_st[3] | m_st[4] | m_st[5]));
    if (rd) m_rd = m_st;
    m_st = ns;
    m_en = en_n;
    e.st = m_st; e.rd = m_rd; e.irq = irq_n; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (status_o !== e.st || rd_data !== e.rd || irq_o !== e.irq) begin
        fails++;
        $display("FAIL %s: status=%h rd=%h irq=%b expected status=%h rd=%h irq=%b",
                 e.tag, status_o, rd_data, irq_o, e.st, e.rd, e.irq);
      end
    end
  end

  initial begin
    bit done = 0;
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now(status_o, '0, "R1 status in reset");
        check_now(rd_data, '0, "R1 read data in reset");
        check_now({{(W-1){1'b0}}, irq_o}, '0, "R1 irq in reset");
        rst = 1'b0;
        step(6'b000000, 0, 1, 32'h0000_00E0, 0, "R7 enable all groups");
        step(6'b000001, 0, 0, '0, 0, "R2 transmit demand pulse");
        step(6'b000000, 0, 0, '0, 0, "R6 transmit set with enable");
        step(6'b000000, 0, 1, 32'h0000_00C0, 0, "R6 transmit enable off");
        step(6'b000000, 0, 0, '0, 0, "R7 irq off when group disabled");
        step(6'b000000, 1, 0, 32'h0000_0000, 0, "R3 zero write keeps bit");
        step(6'b000000, 1, 0, 32'h0000_0001, 0, "R3 one write clears transmit demand");
        step(6'b111000, 0, 0, '0, 0, "R2 error events latch");
        step(6'b000000, 1, 0, 32'h0000_0010, 0, "R3 clear break only");
        step(6'b100000, 1, 0, 32'h0000_0020, 0, "R4 event beats clear");
        step(6'b000000, 0, 0, '0, 0, "R7 error group irq");
        step(6'b000000, 1, 0, 32'h0000_0028, 0, "R3 clear frame and overrun");
        step(6'b000000, 0, 0, '0, 0, "R7 irq drops after clear");
        step(6'b000010, 0, 0, '0, 0, "R5 receive trigger level");
        step(6'b000110, 1, 0, 32'h0000_0006, 0, "R5 write cannot clear live bits");
        step(6'b000100, 0, 0, '0, 0, "R5 trigger level falls");
        step(6'b000000, 0, 0, '0, 0, "R5 timeout level falls");
        step(6'b000010, 0, 1, 32'h0000_0080, 0, "R7 receive group disabled");
        step(6'b000010, 0, 0, '0, 0, "R7 receive masked");
        step(6'b001000, 0, 0, '0, 0, "R2 frame event again");
        step(6'b000000, 0, 0, '0, 1, "R8 read strobe captures");
        step(6'b000000, 0, 0, '0, 0, "R8 read has no side effect");
        step(6'b000001, 0, 0, '0, 0, "R8 read data holds");
        step(6'b000000, 0, 0, '0, 1, "R8 second read");
        step(6'b111111, 0, 1, '1, 1, "R9 upper bits zero after control ones");
        step(6'b000000, 1, 0, '1, 0, "R9 all ones status write");
        step(6'b000000, 0, 0, '0, 1, "R9 read of cleared word");
        step(6'b000000, 0, 0, '0, 0, "R7 idle");
        @(negedge clk);
        done = 1;
      end
      begin
        #80000;
      end
    join_any
    disable fork;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=complete");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule